// File: doc/BRIEF.md
# L3 Control Bus Master

This block is the master side of a three-wire control bus used to configure an audio codec. It drives a serial clock line and a mode line, and it drives or releases a shared data line. A single command carries an address byte, a read/write flag and a data-byte count of one up to `MAX_DATA`. The block then runs the whole transaction on its own and reports completion.

The mode line separates the address phase from the data phase. Consecutive data bytes in one transaction are divided by a halt, which is one long low pulse on the clock line. For a read, the master stops driving the data line once the address byte is done, and it collects the bytes that the codec shifts back. Every interval on the bus is a parameter counted in system clock cycles, with a minimum of one cycle each: bit low time, bit high time, mode setup, mode hold and halt.

Top module: `l3_master`

## Requirements
- R1: Out of reset and between transactions the bus is idle. In this state `l3_clk_o` and `l3_mode_o` are 1, `l3_data_oe_o` is 0, and `busy_o` and `done_o` are 0.
- R2: Each byte is sent as 8 bits, least significant bit first. The bit value on `l3_data_o` is present while the clock is low and does not change at the rising clock edge.
- R3: Each bit is one clock-low interval of `T_LOW` cycles followed by a clock-high interval of `T_HIGH` cycles.
- R4: `l3_mode_o` is 0 from the start of a transaction through the address byte and its hold. It is 1 through every data byte, including the halts.
- R5: `T_SETUP` clock-high cycles come before the address byte and before each data byte. `T_HOLD` clock-high cycles follow every byte, after that byte's last bit-high interval.
- R6: Each data byte after the first is preceded by a halt. The halt holds the clock low for `T_HALT` cycles. It comes after the previous byte's hold and before this byte's setup.
- R7: A write sends `len_i`+1 data bytes (`len_i`=0 gives one byte, 1 gives two). Data byte k is `wdata_i[8k+7:8k]`, captured at start. `l3_data_oe_o` stays 1 for the whole transaction.
- R8: On a read, `l3_data_oe_o` drops after the address hold and stays 0 for the data bytes. `l3_data_i` is sampled in the last cycle of each clock-low interval, with the first sampled bit taken as bit 0. Read byte k appears on `rdata_o[8k+7:8k]` by the time `done_o` pulses.
- R9: `busy_o` rises in the cycle after a `start_i` that is accepted in idle, and it stays high until the transaction ends. A `start_i` seen while busy is ignored: it does not alter or extend the transaction, and it does not start another.
- R10: `done_o` is a single-cycle pulse, asserted in the first idle cycle after the final hold. For n data bytes, `busy_o` is high for exactly (n+1)·(`T_SETUP`+8·(`T_LOW`+`T_HIGH`)+`T_HOLD`)+(n-1)·`T_HALT` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled in idle |
| rd_i | input | 1 | 1 = read transaction, 0 = write |
| len_i | input | LEN_W | Data byte count minus one |
| addr_i | input | 8 | Address byte |
| wdata_i | input | 8·MAX_DATA | Write bytes, byte 0 in the low bits |
| rdata_o | output | 8·MAX_DATA | Read bytes, byte 0 in the low bits |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| l3_clk_o | output | 1 | Bus clock line |
| l3_mode_o | output | 1 | Bus mode line: 0 address, 1 data |
| l3_data_o | output | 1 | Bus data line, output value |
| l3_data_oe_o | output | 1 | Bus data line output enable |
| l3_data_i | input | 1 | Bus data line, input value |

## Verification
The bench sets every interval to a different value, so a timing slot mixed up with another one shows up as a wrong pulse width or a wrong gap. It checks the long gap between the address and the first data byte (high time + hold + setup). A design that leaves out the setup or the hold there, or that inserts a halt before the first data byte, gets this gap wrong. It also checks the halt between data bytes. A bit order that is reversed, or a mode line that flips one byte too late, corrupts the captured address. On reads, the bench shifts the slave's bits only on true bit pulses. A design that samples on the wrong edge, or that treats the halt as a bit, returns shifted read data. A start pulse in the middle of a transaction must leave the address, the pulse count and the number of done pulses unchanged.

// File: rtl/l3m_pkg.sv
package l3m_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_HOLD,
    ST_HALT
  } l3_state_e;

  function automatic int l3m_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/l3m_timer.sv
module l3m_timer #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_TMR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(val_i))); // R3
  AST_TMR_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && zero_o) |=> zero_o); // R3
endmodule

// File: rtl/l3m_shift.sv
module l3m_shift #(
  parameter int MAX_DATA = 2,
  parameter int IW       = 2,
  localparam int DW      = 8 * MAX_DATA
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [7:0]    load_byte_i,
  input  logic          shift_i,
  input  logic          sample_i,
  input  logic          sdi_i,
  input  logic          store_i,
  input  logic [IW-1:0] store_idx_i,
  output logic          bit_o,
  output logic [DW-1:0] rdata_o
);
  logic [7:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '0;
    else if (load_i)   sr_q <= load_byte_i;
    else if (sample_i) sr_q <= {sdi_i, sr_q[7:1]};
    else if (shift_i)  sr_q <= {1'b0, sr_q[7:1]};
  end

  assign bit_o = sr_q[0];

  for (genvar g = 0; g < MAX_DATA; g++) begin : g_rbuf
    logic [7:0] rb_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    rb_q <= '0;
      else if (store_i && (store_idx_i == IW'(g)))    rb_q <= sr_q;
    end
    assign rdata_o[8*g +: 8] = rb_q;
  end

  AST_SR_ONE_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({load_i, shift_i, sample_i})); // R2
  AST_STORE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_i |-> (int'(store_idx_i) < MAX_DATA)); // R8
endmodule

// File: rtl/l3m_fsm.sv
module l3m_fsm
  import l3m_pkg::*;
#(
  parameter int MAX_DATA = 2,
  parameter int T_LOW    = 4,
  parameter int T_HIGH   = 4,
  parameter int T_SETUP  = 2,
  parameter int T_HOLD   = 2,
  parameter int T_HALT   = 3,
  parameter int LEN_W    = 1,
  parameter int IW       = 2,
  parameter int CW       = 4,
  localparam int DW      = 8 * MAX_DATA
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rd_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             tmr_zero_i,
  output logic             tmr_load_o,
  output logic [CW-1:0]    tmr_val_o,
  output logic             sr_load_o,
  output logic [7:0]       sr_byte_o,
  output logic             sr_shift_o,
  output logic             sr_sample_o,
  output logic             rd_store_o,
  output logic [IW-1:0]    rd_idx_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             l3_clk_o,
  output logic             l3_mode_o,
  output logic             l3_data_oe_o
);
  l3_state_e       state_q;
  logic [2:0]      bit_q;
  logic [IW-1:0]   byte_q;   // 0 = address, k+1 = data byte k
  logic [IW-1:0]   last_q;
  logic            rd_q;
  logic [DW-1:0]   wdata_q;
  logic            done_q;
  logic            in_data;

  assign in_data = (byte_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      byte_q  <= '0;
      last_q  <= '0;
      rd_q    <= 1'b0;
      wdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          rd_q    <= rd_i;
          last_q  <= IW'(len_i) + 1'b1;
          wdata_q <= wdata_i;
          byte_q  <= '0;
          bit_q   <= '0;
          state_q <= ST_SETUP;
        end
        ST_SETUP: if (tmr_zero_i) state_q <= ST_LOW;
        ST_LOW:   if (tmr_zero_i) state_q <= ST_HIGH;
        ST_HIGH:  if (tmr_zero_i) begin
          if (bit_q == 3'd7) state_q <= ST_HOLD;
          else begin
            bit_q   <= bit_q + 1'b1;
            state_q <= ST_LOW;
          end
        end
        ST_HOLD: if (tmr_zero_i) begin
          if (byte_q == last_q) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            byte_q  <= byte_q + 1'b1;
            bit_q   <= '0;
            state_q <= in_data ? ST_HALT : ST_SETUP;
          end
        end
        ST_HALT: if (tmr_zero_i) state_q <= ST_SETUP;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    tmr_load_o  = 1'b0;
    tmr_val_o   = '0;
    sr_load_o   = 1'b0;
    sr_byte_o   = addr_i;
    sr_shift_o  = 1'b0;
    sr_sample_o = 1'b0;
    rd_store_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        tmr_load_o = 1'b1;
        tmr_val_o  = CW'(T_SETUP - 1);
        sr_load_o  = 1'b1;
      end
      ST_SETUP: if (tmr_zero_i) begin
        tmr_load_o = 1'b1;
        tmr_val_o  = CW'(T_LOW - 1);
      end
      ST_LOW: if (tmr_zero_i) begin
        tmr_load_o  = 1'b1;
        tmr_val_o   = CW'(T_HIGH - 1);
        sr_sample_o = rd_q && in_data;
      end
      ST_HIGH: if (tmr_zero_i) begin
        tmr_load_o = 1'b1;
        if (bit_q == 3'd7) tmr_val_o = CW'(T_HOLD - 1);
        else begin
          tmr_val_o  = CW'(T_LOW - 1);
          sr_shift_o = !(rd_q && in_data);
        end
      end
      ST_HOLD: if (tmr_zero_i) begin
        rd_store_o = rd_q && in_data;
        if (byte_q != last_q) begin
          tmr_load_o = 1'b1;
          tmr_val_o  = in_data ? CW'(T_HALT - 1) : CW'(T_SETUP - 1);
          sr_load_o  = 1'b1;
          sr_byte_o  = 8'(wdata_q >> {byte_q, 3'b000});
        end
      end
      ST_HALT: if (tmr_zero_i) begin
        tmr_load_o = 1'b1;
        tmr_val_o  = CW'(T_SETUP - 1);
      end
      default: ;
    endcase
  end

  assign rd_idx_o     = byte_q - 1'b1;
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign l3_clk_o     = !((state_q == ST_LOW) || (state_q == ST_HALT));
  assign l3_mode_o    = !busy_o || in_data;
  assign l3_data_oe_o = busy_o && (!in_data || !rd_q);

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R10
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(rd_q) && $stable(last_q) && $stable(wdata_q))); // R9
  AST_MODE_ADDR_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !l3_mode_o); // R4
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (l3_clk_o && l3_mode_o && !l3_data_oe_o)); // R1
  AST_READ_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rd_q && l3_mode_o) |-> !l3_data_oe_o); // R8
endmodule

// File: rtl/l3_master.sv
module l3_master
  import l3m_pkg::*;
#(
  parameter int MAX_DATA = 2,
  parameter int T_LOW    = 4,
  parameter int T_HIGH   = 4,
  parameter int T_SETUP  = 2,
  parameter int T_HOLD   = 2,
  parameter int T_HALT   = 3,
  localparam int LEN_W   = (MAX_DATA > 1) ? $clog2(MAX_DATA) : 1,
  localparam int DW      = 8 * MAX_DATA
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rd_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             l3_clk_o,
  output logic             l3_mode_o,
  output logic             l3_data_o,
  output logic             l3_data_oe_o,
  input  logic             l3_data_i
);
  localparam int TMAX = l3m_max(l3m_max(l3m_max(T_LOW, T_HIGH), l3m_max(T_SETUP, T_HOLD)), T_HALT);
  localparam int CW   = $clog2(TMAX + 1);
  localparam int IW   = $clog2(MAX_DATA + 1);

  logic          tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;
  logic          sr_load, sr_shift, sr_sample, sr_bit;
  logic [7:0]    sr_byte;
  logic          rd_store;
  logic [IW-1:0] rd_idx;

  l3m_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  l3m_fsm #(
    .MAX_DATA (MAX_DATA),
    .T_LOW    (T_LOW),
    .T_HIGH   (T_HIGH),
    .T_SETUP  (T_SETUP),
    .T_HOLD   (T_HOLD),
    .T_HALT   (T_HALT),
    .LEN_W    (LEN_W),
    .IW       (IW),
    .CW       (CW)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .rd_i         (rd_i),
    .len_i        (len_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .tmr_zero_i   (tmr_zero),
    .tmr_load_o   (tmr_load),
    .tmr_val_o    (tmr_val),
    .sr_load_o    (sr_load),
    .sr_byte_o    (sr_byte),
    .sr_shift_o   (sr_shift),
    .sr_sample_o  (sr_sample),
    .rd_store_o   (rd_store),
    .rd_idx_o     (rd_idx),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .l3_clk_o     (l3_clk_o),
    .l3_mode_o    (l3_mode_o),
    .l3_data_oe_o (l3_data_oe_o)
  );

  l3m_shift #(.MAX_DATA(MAX_DATA), .IW(IW)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (sr_load),
    .load_byte_i (sr_byte),
    .shift_i     (sr_shift),
    .sample_i    (sr_sample),
    .sdi_i       (l3_data_i),
    .store_i     (rd_store),
    .store_idx_i (rd_idx),
    .bit_o       (sr_bit),
    .rdata_o     (rdata_o)
  );

  assign l3_data_o = l3_data_oe_o & sr_bit;

  AST_DATA_STABLE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(l3_clk_o) && l3_data_oe_o && $past(l3_data_oe_o)) |-> $stable(l3_data_o)); // R2
  AST_TIMER_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$past(busy_o)) |-> !tmr_zero || (T_SETUP == 1)); // R5
endmodule

// File: tb/tb_l3_master.sv
module tb_l3_master;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_DATA = 2;
  localparam int TL = 2, TH = 3, TS = 4, TD = 5, TA = 6;
  localparam int NP = 32;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, rd = 1'b0;
  logic [0:0]  len = '0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        busy, done, l3_clk, l3_mode, l3_dout, l3_oe, l3_din;
  logic [15:0] slave_data = '0;

  int n_chk = 0, n_fail = 0;
  int txn_id = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  l3_master #(
    .MAX_DATA(MAX_DATA), .T_LOW(TL), .T_HIGH(TH),
    .T_SETUP(TS), .T_HOLD(TD), .T_HALT(TA)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rd_i(rd), .len_i(len),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy),
    .done_o(done), .l3_clk_o(l3_clk), .l3_mode_o(l3_mode),
    .l3_data_o(l3_dout), .l3_data_oe_o(l3_oe), .l3_data_i(l3_din)
  );

  // bus monitor and read-slave model, sampled at negedge
  int   np, busy_cnt, done_cnt, highlen, lowlen, pre_q, slave_idx, seen_id;
  logic prev_clk, cur_bit, cur_mode, cur_oe;
  logic p_bit[NP], p_mode[NP], p_oe[NP];
  int   p_len[NP], p_pre[NP];

  assign l3_din = (slave_idx < 16) ? slave_data[slave_idx] : 1'b0;

  initial begin
    np = 0; busy_cnt = 0; done_cnt = 0; highlen = 0; lowlen = 0; pre_q = 0;
    slave_idx = 0; seen_id = 0; prev_clk = 1'b1;
    cur_bit = 1'b0; cur_mode = 1'b1; cur_oe = 1'b0;
  end

  always @(negedge clk) begin
    if (seen_id != txn_id) begin
      seen_id = txn_id;
      np = 0; busy_cnt = 0; done_cnt = 0; highlen = 0; lowlen = 0; slave_idx = 0;
    end
    if (busy) busy_cnt++;
    if (done) done_cnt++;
    if (!l3_clk) begin
      if (prev_clk) begin pre_q = highlen; highlen = 0; lowlen = 0; end
      lowlen++;
      cur_bit = l3_dout; cur_mode = l3_mode; cur_oe = l3_oe;
    end else begin
      if (!prev_clk) begin
        if (np < NP) begin
          p_bit[np] = cur_bit; p_mode[np] = cur_mode; p_oe[np] = cur_oe;
          p_len[np] = lowlen; p_pre[np] = pre_q;
        end
        np++;
        if (cur_mode && !cur_oe && lowlen == TL) slave_idx++;
      end
      if (busy) highlen++;
    end
    prev_clk = l3_clk;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic check_idle(input string tag);
    chk("R1", {tag, " clk"}, int'(l3_clk), 1);
    chk("R1", {tag, " mode"}, int'(l3_mode), 1);
    chk("R1", {tag, " oe"}, int'(l3_oe), 0);
    chk("R1", {tag, " busy"}, int'(busy), 0);
    chk("R1", {tag, " done"}, int'(done), 0);
  endtask

  task automatic issue(input bit r, input int nd, input logic [7:0] a,
                       input logic [15:0] wd, input logic [15:0] sd);
    txn_id++;
    slave_data = sd;
    cyc(1);
    rd = r; len = 1'(nd - 1); addr = a; wdata = wd; start = 1'b1;
    cyc(1);
    start = 1'b0;
    chk("R9", "busy after start", int'(busy), 1);
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 2000) begin cyc(1); t++; end
    chk("R10", "done seen", int'(done), 1);
    cyc(3);
  endtask

  task automatic check_txn(input bit r, input int nd, input logic [7:0] a,
                           input logic [15:0] wd, input logic [15:0] sd);
    int idx;
    logic [7:0] b;
    int bad_mode, bad_len, bad_oe;
    chk("R2", "pulse count", np, 8 + 8*nd + (nd - 1));
    if (np > NP) return;
    b = '0; bad_mode = 0; bad_len = 0;
    for (int i = 0; i < 8; i++) begin
      b[i] = p_bit[i];
      if (p_mode[i]) bad_mode++;
      if (p_len[i] != TL) bad_len++;
      if (i > 0 && p_pre[i] != TH) bad_len++;
    end
    chk("R2", "address byte LSB first", int'(b), int'(a));
    chk("R4", "mode low in address", bad_mode, 0);
    chk("R3", "address bit timing", bad_len, 0);
    chk("R5", "setup before address", p_pre[0], TS);
    idx = 8;
    for (int k = 0; k < nd; k++) begin
      if (k > 0) begin
        chk("R6", "halt width", p_len[idx], TA);
        chk("R6", "gap before halt", p_pre[idx], TH + TD);
        chk("R4", "mode high in halt", int'(p_mode[idx]), 1);
        idx++;
        chk("R5", "setup after halt", p_pre[idx], TS);
      end else begin
        chk("R5", "hold+setup before data", p_pre[idx], TH + TD + TS);
      end
      b = '0; bad_mode = 0; bad_oe = 0; bad_len = 0;
      for (int i = 0; i < 8; i++) begin
        b[i] = p_bit[idx + i];
        if (!p_mode[idx + i]) bad_mode++;
        if (p_oe[idx + i] == r) bad_oe++;
        if (p_len[idx + i] != TL) bad_len++;
      end
      chk("R4", "mode high in data", bad_mode, 0);
      chk("R3", "data bit low width", bad_len, 0);
      if (r) begin
        chk("R8", "data released on read", bad_oe, 0);
        chk("R8", "read byte", int'(rdata[8*k +: 8]), int'(sd[8*k +: 8]));
      end else begin
        chk("R7", "data driven on write", bad_oe, 0);
        chk("R7", "write byte", int'(b), int'(wd[8*k +: 8]));
      end
      idx += 8;
    end
    chk("R10", "busy length", busy_cnt,
        (nd + 1) * (TS + 8*(TL + TH) + TD) + (nd - 1) * TA);
    chk("R10", "single done", done_cnt, 1);
    check_idle("after txn");
  endtask

  task automatic t_reset();
    check_idle("reset");
  endtask

  task automatic t_write_one();  // R7
    issue(1'b0, 1, 8'h5A, 16'h003C, '0);
    wait_done();
    check_txn(1'b0, 1, 8'h5A, 16'h003C, '0);
  endtask

  task automatic t_write_two();  // R6
    issue(1'b0, 2, 8'hC3, 16'h7E81, '0);
    wait_done();
    check_txn(1'b0, 2, 8'hC3, 16'h7E81, '0);
  endtask

  task automatic t_write_edges();
    issue(1'b0, 2, 8'hFF, 16'hFF00, '0);
    wait_done();
    check_txn(1'b0, 2, 8'hFF, 16'hFF00, '0);
    issue(1'b0, 2, 8'h01, 16'h8001, '0);
    wait_done();
    check_txn(1'b0, 2, 8'h01, 16'h8001, '0);
  endtask

  task automatic t_read_one();  // R8
    issue(1'b1, 1, 8'h96, '0, 16'h00A5);
    wait_done();
    check_txn(1'b1, 1, 8'h96, '0, 16'h00A5);
  endtask

  task automatic t_read_two();  // R8
    issue(1'b1, 2, 8'h0F, '0, 16'hF012);
    wait_done();
    check_txn(1'b1, 2, 8'h0F, '0, 16'hF012);
  endtask

  task automatic t_busy_ignore();  // R9
    issue(1'b0, 1, 8'h3C, 16'h00C6, '0);
    cyc(20);
    rd = 1'b1; len = 1'b1; addr = 8'hE7; wdata = 16'h5555; start = 1'b1;
    cyc(1);
    start = 1'b0;
    wait_done();
    check_txn(1'b0, 1, 8'h3C, 16'h00C6, '0);
    cyc(5);
    chk("R9", "no restart after ignored start", int'(busy), 0);
  endtask

  initial begin : watchdog
    int cnt = 0;
    while (cnt < 100000) begin @(posedge clk); cnt++; end
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cnt, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 1);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_write_one();
    t_write_two();
    t_write_edges();
    t_read_one();
    t_read_two();
    t_busy_ignore();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule